// File: doc/BRIEF.md
# Multichannel SPI Channel Sequencer

This block holds the per-channel transfer control of a four-channel SPI master. Every channel keeps a configuration word, a three-bit status word, an enable bit, a transmit word and a receive word. Software reaches them through a small host port that selects a channel and one of four registers. The block decides when a channel may start a word transfer, hands the word to a shared serial shift engine through a start/done handshake, and updates the status flags when the word ends. It drives a transmit and a receive DMA request per channel and pulses per-channel events when the transmit-empty or receive-full condition comes up.

A start check runs only when a trigger arrives: a transmit write, a receive read or an enable change from 0 to 1. Each channel runs a three-state machine. In IDLE, a pending check that finds the channel ready takes IDLE->REQ when the engine is needed. When the engine is not needed, the word ends in place and the channel stays in IDLE. A check that finds the channel blocked drops the trigger. REQ->BUSY happens on a grant and BUSY->IDLE on the engine's done. The shared engine side has two states. ENG_IDLE->ENG_RUN happens when any channel requests, and the lowest-numbered requester is granted. ENG_RUN->ENG_IDLE happens on done.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset every channel has status 3'b010, configuration 0x060000, enable 0, transmit and receive words 0, and no DMA request. The status bits are: bit 0 receive-full (RXS), bit 1 transmit-empty (TXS), bit 2 end-of-transfer (EOT).
- R2: Configuration bits 13:12 hold the mode: 0 transmit and receive, 1 receive-only, 2 transmit-only. Bits 11:7 hold the word-length field. `ch_cfg_err` is high when the mode is 3 or the length field is below 3. Mode 3 otherwise acts as mode 0.
- R3: Host select 0 is configuration, 1 is enable (bit 0), 2 is the transmit word and 3 is the receive word. A transmit write clears TXS and triggers a start check. A receive read (`host_re`) returns the receive word, clears RXS and triggers a check. An enable change from 0 to 1 triggers a check.
- R4: A check starts nothing if enable is 0, if RXS is set with mode not 2 and turbo (configuration bit 19) off, or if TXS is set with mode not 1.
- R5: When a word ends, the transmit word clears and EOT and TXS set. RXS sets unless the mode is 2. After an engine transfer, the receive word takes `eng_rxd`.
- R6: The engine is used only when `single_chan_mode` is 0 or the force bit (configuration bit 20) is 1. Otherwise the word ends at once with no engine start and the receive word is unchanged.
- R7: An engine start presents the channel index, a length of the field plus one, and the transmit word.
- R8: The transmit DMA request is enable AND bit 14 AND TXS AND mode not 1. The receive DMA request is enable AND bit 15 AND RXS AND mode not 2.
- R9: `tx_empty_evt` pulses for one cycle when (TXS and mode not 1) goes from 0 to 1. `rx_full_evt` pulses for one cycle when (RXS and mode not 2 and turbo off) goes from 0 to 1.
- R10: A channel has at most one word outstanding. A transmit write while in REQ or BUSY is held and applied at done: the word is loaded, TXS stays clear and a new check follows.
- R11: Only one engine transfer runs at a time. Among requesting channels, the lowest index is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_chan_mode | input | 1 | Module in single-channel mode |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (side effect on select 3) |
| host_ch | input | CH_W | Channel addressed by the host |
| host_sel | input | 2 | Register select |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Selected register, combinational |
| ch_status | output | NUM_CH*3 | Status words, channel c at bits 3c+2:3c |
| ch_cfg_err | output | NUM_CH | Illegal mode or length per channel |
| tx_dma_req | output | NUM_CH | Transmit DMA requests |
| rx_dma_req | output | NUM_CH | Receive DMA requests |
| tx_empty_evt | output | NUM_CH | Transmit-empty event pulses |
| rx_full_evt | output | NUM_CH | Receive-full event pulses |
| eng_start | output | 1 | Engine start strobe |
| eng_ch | output | CH_W | Channel of the started word |
| eng_len | output | 6 | Word length in bits |
| eng_txd | output | DATA_W | Word to shift out |
| eng_done | input | 1 | Engine finished the word |
| eng_rxd | input | DATA_W | Word shifted in |

## Verification
The hardest situations to reach are those where several channels wait in REQ while the engine is busy, and where a transmit write lands while its own channel's word is still in flight. Both need the engine to stay busy long enough, so the bench's engine model takes a stretched done delay for these cases. In one case three channels are enabled in quick succession behind a long transfer, and the order of the next starts is checked. In the other, a second transmit word is written during BUSY and the bench confirms that it is held until the receive word is read.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int CFG_W     = 23;
    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;
    localparam int WL_LSB    = 7;
    localparam int WL_W      = 5;
    localparam int MODE_LSB  = 12;
    localparam int TXDMA_BIT = 14;
    localparam int RXDMA_BIT = 15;
    localparam int TURBO_BIT = 19;
    localparam int FORCE_BIT = 20;
    localparam int ST_RXS    = 0;
    localparam int ST_TXS    = 1;
    localparam int ST_EOT    = 2;
    localparam int ST_W      = 3;

    typedef enum logic [1:0] {
        XM_BOTH    = 2'd0,
        XM_RX_ONLY = 2'd1,
        XM_TX_ONLY = 2'd2,
        XM_BAD     = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG = 2'd0,
        SEL_EN  = 2'd1,
        SEL_TX  = 2'd2,
        SEL_RX  = 2'd3
    } host_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_REQ,
        CH_BUSY
    } ch_state_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;
endpackage

// File: rtl/spi_seq_chan.sv
module spi_seq_chan
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              single_mode,
    input  logic              cfg_we,
    input  logic              en_we,
    input  logic              tx_we,
    input  logic              rx_re,
    input  logic [DATA_W-1:0] wdata,
    input  logic              grant,
    input  logic              done,
    input  logic [DATA_W-1:0] eng_rxd,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              en_q,
    output logic [ST_W-1:0]   status,
    output logic [DATA_W-1:0] tx_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              req,
    output logic              in_flight,
    output logic [LEN_W-1:0]  len,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              tx_evt,
    output logic              rx_evt,
    output logic              cfg_err
);
    ch_state_e   state, state_nx;
    xfer_mode_e  mode;
    logic        pend, q_valid, tx_cond_q, rx_cond_q;
    logic [DATA_W-1:0] q_data;
    logic        turbo, force_x, rx_block, tx_block, ready, shift_ok;
    logic        trig, local_done, eng_finish, finish, direct_tx;

    assign mode     = xfer_mode_e'(cfg_q[MODE_LSB +: 2]);
    assign turbo    = cfg_q[TURBO_BIT];
    assign force_x  = cfg_q[FORCE_BIT];
    assign rx_block = status[ST_RXS] && (mode != XM_TX_ONLY) && !turbo;
    assign tx_block = status[ST_TXS] && (mode != XM_RX_ONLY);
    assign ready    = en_q && !rx_block && !tx_block;
    assign shift_ok = !single_mode || force_x;
    assign trig     = tx_we || rx_re || (en_we && wdata[0] && !en_q);

    assign local_done = (state == CH_IDLE) && pend && ready && !shift_ok;
    assign eng_finish = (state == CH_BUSY) && done;
    assign finish     = local_done || eng_finish;
    assign direct_tx  = (state == CH_IDLE) || eng_finish;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (pend && ready && shift_ok) state_nx = CH_REQ;
            CH_REQ:  if (grant) state_nx = CH_BUSY;
            CH_BUSY: if (done)  state_nx = CH_IDLE;
            default: state_nx = CH_IDLE;
        endcase
    end

    // channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= CFG_RST;
            en_q      <= 1'b0;
            status    <= 3'b010;
            tx_q      <= '0;
            rx_q      <= '0;
            pend      <= 1'b0;
            q_valid   <= 1'b0;
            q_data    <= '0;
            tx_cond_q <= 1'b1;
            rx_cond_q <= 1'b0;
        end else begin
            tx_cond_q <= tx_block;
            rx_cond_q <= rx_block;
            if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
            if (en_we)  en_q  <= wdata[0];
            if (state == CH_IDLE && pend) pend <= 1'b0;
            if (rx_re) status[ST_RXS] <= 1'b0;
            if (finish) begin
                tx_q           <= '0;
                status[ST_EOT] <= 1'b1;
                status[ST_TXS] <= 1'b1;
                if (mode != XM_TX_ONLY) status[ST_RXS] <= 1'b1;
                if (eng_finish) rx_q <= eng_rxd;
                if (eng_finish && q_valid) begin
                    tx_q           <= q_data;
                    status[ST_TXS] <= 1'b0;
                    pend           <= 1'b1;
                    q_valid        <= 1'b0;
                end
            end
            if (tx_we) begin
                if (direct_tx) begin
                    tx_q           <= wdata;
                    status[ST_TXS] <= 1'b0;
                    q_valid        <= 1'b0;
                end else begin
                    q_valid <= 1'b1;
                    q_data  <= wdata;
                end
            end
            if (trig) pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        req       = (state == CH_REQ);
        in_flight = (state == CH_BUSY);
        len       = LEN_W'(cfg_q[WL_LSB +: WL_W]) + LEN_W'(1);
        tx_dreq   = en_q && cfg_q[TXDMA_BIT] && status[ST_TXS] && (mode != XM_RX_ONLY);
        rx_dreq   = en_q && cfg_q[RXDMA_BIT] && status[ST_RXS] && (mode != XM_TX_ONLY);
        tx_evt    = tx_block && !tx_cond_q;
        rx_evt    = rx_block && !rx_cond_q;
        cfg_err   = (mode == XM_BAD) || (cfg_q[WL_LSB +: WL_W] < WL_W'(3));
    end

    assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(en_q));
    assert_end_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_finish && !q_valid && !tx_we) |=> (status[ST_TXS] && status[ST_EOT] && tx_q == '0));
    assert_queue_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> (state != CH_IDLE));
    assert_evt_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> !tx_evt);
endmodule

// File: rtl/spi_seq_arb.sv
module spi_seq_arb
    import spi_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic              eng_done,
    output logic [NUM_CH-1:0] grant,
    output logic [NUM_CH-1:0] done_vec,
    output logic              eng_start,
    output logic [CH_W-1:0]   pick
);
    eng_state_e state, state_nx;
    logic [CH_W-1:0] owner;

    // lowest index wins
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (req[i]) pick = CH_W'(i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
            owner <= '0;
        end else begin
            state <= state_nx;
            if (eng_start) owner <= pick;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE: if (|req)    state_nx = ENG_RUN;
            ENG_RUN:  if (eng_done) state_nx = ENG_IDLE;
            default:  state_nx = ENG_IDLE;
        endcase
    end

    always_comb begin
        eng_start = (state == ENG_IDLE) && (|req);
        for (int i = 0; i < NUM_CH; i++) begin
            grant[i]    = eng_start && (pick == CH_W'(i));
            done_vec[i] = (state == ENG_RUN) && eng_done && (owner == CH_W'(i));
        end
    end

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_to_requester_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    assert_lowest_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - NUM_CH'(1)) & req) == '0));
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int LEN_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 single_chan_mode,
    input  logic                 host_we,
    input  logic                 host_re,
    input  logic [CH_W-1:0]      host_ch,
    input  logic [1:0]           host_sel,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [NUM_CH*ST_W-1:0] ch_status,
    output logic [NUM_CH-1:0]    ch_cfg_err,
    output logic [NUM_CH-1:0]    tx_dma_req,
    output logic [NUM_CH-1:0]    rx_dma_req,
    output logic [NUM_CH-1:0]    tx_empty_evt,
    output logic [NUM_CH-1:0]    rx_full_evt,
    output logic                 eng_start,
    output logic [CH_W-1:0]      eng_ch,
    output logic [LEN_W-1:0]     eng_len,
    output logic [DATA_W-1:0]    eng_txd,
    input  logic                 eng_done,
    input  logic [DATA_W-1:0]    eng_rxd
);
    host_sel_e sel;
    logic [CFG_W-1:0]  cfg_a [NUM_CH];
    logic [DATA_W-1:0] tx_a  [NUM_CH];
    logic [DATA_W-1:0] rx_a  [NUM_CH];
    logic [LEN_W-1:0]  len_a [NUM_CH];
    logic [NUM_CH-1:0] en_v, req_v, fl_v, grant_v, done_v;

    assign sel = host_sel_e'(host_sel);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = (host_ch == CH_W'(c));
        spi_seq_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .single_mode(single_chan_mode),
            .cfg_we(host_we && hit && sel == SEL_CFG),
            .en_we (host_we && hit && sel == SEL_EN),
            .tx_we (host_we && hit && sel == SEL_TX),
            .rx_re (host_re && hit && sel == SEL_RX),
            .wdata(host_wdata), .grant(grant_v[c]), .done(done_v[c]), .eng_rxd(eng_rxd),
            .cfg_q(cfg_a[c]), .en_q(en_v[c]), .status(ch_status[c*ST_W +: ST_W]),
            .tx_q(tx_a[c]), .rx_q(rx_a[c]), .req(req_v[c]), .in_flight(fl_v[c]),
            .len(len_a[c]), .tx_dreq(tx_dma_req[c]), .rx_dreq(rx_dma_req[c]),
            .tx_evt(tx_empty_evt[c]), .rx_evt(rx_full_evt[c]), .cfg_err(ch_cfg_err[c])
        );
    end

    spi_seq_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_v), .eng_done(eng_done),
        .grant(grant_v), .done_vec(done_v), .eng_start(eng_start), .pick(eng_ch)
    );

    assign eng_len = len_a[eng_ch];
    assign eng_txd = tx_a[eng_ch];

    always_comb begin
        unique case (sel)
            SEL_CFG: host_rdata = DATA_W'(cfg_a[host_ch]);
            SEL_EN:  host_rdata = DATA_W'(en_v[host_ch]);
            SEL_TX:  host_rdata = tx_a[host_ch];
            SEL_RX:  host_rdata = rx_a[host_ch];
            default: host_rdata = '0;
        endcase
    end

    assert_single_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_v));
    assert_start_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> req_v[eng_ch]);
endmodule

// File: tb/test_spi_chan_seq.sv
module test_spi_chan_seq;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int LOGN = 2048;

    logic clk = 1'b0, rst_n = 1'b0, single_chan_mode = 1'b0;
    logic host_we = 1'b0, host_re = 1'b0;
    logic [1:0] host_ch = '0, host_sel = '0;
    logic [DW-1:0] host_wdata = '0, host_rdata;
    logic [NCH*3-1:0] ch_status;
    logic [NCH-1:0] ch_cfg_err, tx_dma_req, rx_dma_req, tx_empty_evt, rx_full_evt;
    logic eng_start, eng_done = 1'b0;
    logic [1:0] eng_ch;
    logic [5:0] eng_len;
    logic [DW-1:0] eng_txd, eng_rxd = '0;

    spi_chan_seq #(.NUM_CH(NCH), .DATA_W(DW)) i_spi_chan_seq (.*);

    always #2 clk = ~clk;

    int n_cmp = 0, n_bad = 0, eng_delay = 1;
    bit finished = 0;
    logic [22:0] m_cfg [NCH];
    logic        m_en [NCH];
    logic [2:0]  m_st [NCH];
    logic [31:0] m_tx [NCH], m_rx [NCH];
    bit          p_tx [NCH], p_rx [NCH];
    int exp_te [NCH], exp_rf [NCH], obs_te [NCH], obs_rf [NCH];
    int e_ch [LOGN], e_len [LOGN], o_ch [LOGN], o_len [LOGN];
    logic [31:0] e_txd [LOGN], o_txd [LOGN];
    int n_exp = 0, n_obs = 0, n_seen = 0;

    function automatic logic [31:0] rx_pat(int c, logic [31:0] t);
        return {t[15:0], t[31:16]} ^ (32'h1357_9BDF + 32'(c));
    endfunction
    function automatic int mode_of(int c); return int'(m_cfg[c][13:12]); endfunction
    function automatic bit txc(int c); return m_st[c][1] && mode_of(c) != 1; endfunction
    function automatic bit rxc(int c);
        return m_st[c][0] && mode_of(c) != 2 && !m_cfg[c][19];
    endfunction

    task automatic check(string r, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // bench model
    task automatic note(int c);
        if (txc(c) && !p_tx[c]) exp_te[c]++;
        if (rxc(c) && !p_rx[c]) exp_rf[c]++;
        p_tx[c] = txc(c);
        p_rx[c] = rxc(c);
    endtask
    task automatic m_run(int c, bit do_note);
        int md = mode_of(c);
        if (!m_en[c]) return;
        if (m_st[c][0] && md != 2 && !m_cfg[c][19]) return;
        if (m_st[c][1] && md != 1) return;
        if (!single_chan_mode || m_cfg[c][20]) begin
            e_ch[n_exp] = c; e_len[n_exp] = int'(m_cfg[c][11:7]) + 1; e_txd[n_exp] = m_tx[c];
            n_exp++;
            m_rx[c] = rx_pat(c, m_tx[c]);
        end
        m_tx[c] = '0;
        m_st[c][2] = 1'b1; m_st[c][1] = 1'b1;
        if (md != 2) m_st[c][0] = 1'b1;
        if (do_note) note(c);
    endtask
    task automatic m_cfg_w(int c, logic [31:0] v); m_cfg[c] = v[22:0]; note(c); endtask
    task automatic m_en_w(int c, bit v);
        bit rise = v && !m_en[c];
        m_en[c] = v;
        if (rise) m_run(c, 1);
    endtask
    task automatic m_tx_w(int c, logic [31:0] d);
        m_tx[c] = d; m_st[c][1] = 1'b0; note(c); m_run(c, 1);
    endtask

    // host access
    task automatic h_write(int c, int s, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_ch = 2'(c); host_sel = 2'(s); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask
    task automatic h_read_rx(int c, output logic [31:0] d);
        @(negedge clk);
        host_re = 1'b1; host_ch = 2'(c); host_sel = 2'd3;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
    endtask
    task automatic peek(int c, int s, output logic [31:0] d);
        host_ch = 2'(c); host_sel = 2'(s);
        #1 d = host_rdata;
    endtask

    task automatic settle(); repeat (16) @(negedge clk); endtask

    task automatic compare_all();
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            check("R5", 32'(ch_status[c*3 +: 3]), 32'(m_st[c]), $sformatf("status ch%0d", c));
            check("R2", 32'(ch_cfg_err[c]),
                  32'(mode_of(c) == 3 || m_cfg[c][11:7] < 5'd3), $sformatf("cfg_err ch%0d", c));
            check("R8", 32'(tx_dma_req[c]),
                  32'(m_en[c] && m_cfg[c][14] && m_st[c][1] && mode_of(c) != 1), $sformatf("tx dreq ch%0d", c));
            check("R8", 32'(rx_dma_req[c]),
                  32'(m_en[c] && m_cfg[c][15] && m_st[c][0] && mode_of(c) != 2), $sformatf("rx dreq ch%0d", c));
            check("R9", 32'(obs_te[c]), 32'(exp_te[c]), $sformatf("tx-empty events ch%0d", c));
            check("R9", 32'(obs_rf[c]), 32'(exp_rf[c]), $sformatf("rx-full events ch%0d", c));
            peek(c, 0, v);
            check("R3", v, 32'(m_cfg[c]), $sformatf("cfg read ch%0d", c));
            peek(c, 2, v);
            check("R5", v, m_tx[c], $sformatf("tx word ch%0d", c));
        end
        check("R7", 32'(n_obs), 32'(n_exp), "engine start count");
        while (n_seen < n_obs && n_seen < n_exp) begin
            check("R7", 32'(o_ch[n_seen]), 32'(e_ch[n_seen]), $sformatf("start %0d channel", n_seen));
            check("R7", 32'(o_len[n_seen]), 32'(e_len[n_seen]), $sformatf("start %0d length", n_seen));
            check("R7", o_txd[n_seen], e_txd[n_seen], $sformatf("start %0d word", n_seen));
            n_seen++;
        end
    endtask

    task automatic op_cfg(int c, logic [31:0] v); h_write(c, 0, v); m_cfg_w(c, v); settle(); compare_all(); endtask
    task automatic op_en(int c, bit v); h_write(c, 1, 32'(v)); m_en_w(c, v); settle(); compare_all(); endtask
    task automatic op_tx(int c, logic [31:0] d); h_write(c, 2, d); m_tx_w(c, d); settle(); compare_all(); endtask
    task automatic op_rx(int c);
        logic [31:0] d;
        h_read_rx(c, d);
        check("R3", d, m_rx[c], $sformatf("rx read ch%0d", c));
        m_st[c][0] = 1'b0; note(c); m_run(c, 1);
        settle(); compare_all();
    endtask

    // shift engine model
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            while (eng_start) begin
                if (n_obs < LOGN) begin
                    o_ch[n_obs] = int'(eng_ch); o_len[n_obs] = int'(eng_len); o_txd[n_obs] = eng_txd;
                    n_obs++;
                end
                eng_rxd = rx_pat(int'(eng_ch), eng_txd);
                repeat (eng_delay) @(negedge clk);
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    // event counters
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n)
                for (int c = 0; c < NCH; c++) begin
                    if (tx_empty_evt[c]) obs_te[c]++;
                    if (rx_full_evt[c])  obs_rf[c]++;
                end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) begin
            m_cfg[c] = 23'h060000; m_en[c] = 0; m_st[c] = 3'b010; m_tx[c] = 0; m_rx[c] = 0;
            p_tx[c] = 1; p_rx[c] = 0; exp_te[c] = 0; exp_rf[c] = 0; obs_te[c] = 0; obs_rf[c] = 0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            check("R1", 32'(ch_status[c*3 +: 3]), 32'h2, $sformatf("reset status ch%0d", c));
            peek(c, 0, v); check("R1", v, 32'h060000, $sformatf("reset cfg ch%0d", c));
            peek(c, 1, v); check("R1", v, 32'h0, $sformatf("reset enable ch%0d", c));
        end
        check("R1", 32'({tx_dma_req, rx_dma_req}), 32'h0, "reset dma requests");

        // R2 legality flags
        op_cfg(0, 32'h3000 | (32'd7 << 7));
        check("R2", 32'(ch_cfg_err[0]), 32'h1, "mode 3 flagged");
        op_cfg(0, 32'd2 << 7);
        check("R2", 32'(ch_cfg_err[0]), 32'h1, "length field 2 flagged");
        op_cfg(0, 32'd3 << 7);
        check("R2", 32'(ch_cfg_err[0]), 32'h0, "length field 3 legal");

        // R4 disabled channel does not start, R6 engine bypass
        op_tx(1, 32'hCAFE_0001);
        check("R4", 32'(n_obs), 32'(n_exp), "no start while disabled");
        single_chan_mode = 1'b1;
        op_en(1, 1'b1);
        check("R6", 32'(n_obs), 32'h0, "no engine start in single mode without force");
        single_chan_mode = 1'b0;

        // R11 priority: ch3 busy, ch2 and ch1 wait
        eng_delay = 6;
        for (int c = 1; c < NCH; c++) begin
            h_write(c, 0, 32'd15 << 7); m_cfg_w(c, 32'd15 << 7);
            op_rx(c);
            h_write(c, 1, 32'h0); m_en_w(c, 1'b0);
            h_write(c, 2, 32'h1000 + 32'(c)); m_tx_w(c, 32'h1000 + 32'(c));
        end
        settle(); compare_all();
        h_write(3, 1, 32'h1); m_en_w(3, 1'b1);
        h_write(2, 1, 32'h1); m_en_w(2, 1'b1);
        h_write(1, 1, 32'h1); m_en_w(1, 1'b1);
        begin
            // R11: lowest waiting index is granted next
            int tc; int tl; logic [31:0] tw;
            tc = e_ch[n_exp-1]; tl = e_len[n_exp-1]; tw = e_txd[n_exp-1];
            e_ch[n_exp-1] = e_ch[n_exp-2]; e_len[n_exp-1] = e_len[n_exp-2]; e_txd[n_exp-1] = e_txd[n_exp-2];
            e_ch[n_exp-2] = tc; e_len[n_exp-2] = tl; e_txd[n_exp-2] = tw;
        end
        repeat (30) @(negedge clk);
        compare_all();

        // R10 write during BUSY is held until done
        h_write(0, 0, 32'd7 << 7); m_cfg_w(0, 32'd7 << 7);
        op_en(0, 1'b1);
        op_rx(0);
        h_write(0, 2, 32'hAAAA_5555);
        m_tx[0] = 32'hAAAA_5555; m_st[0][1] = 1'b0; note(0); m_run(0, 1'b0);
        repeat (2) @(negedge clk);
        h_write(0, 2, 32'h1234_5678);
        m_tx[0] = 32'h1234_5678; m_st[0][1] = 1'b0; note(0);
        settle(); compare_all();
        check("R10", 32'(ch_status[2:0]), 32'h5, "queued word keeps TXS clear");
        op_rx(0);
        check("R10", 32'(n_obs), 32'(n_exp), "queued word started after read");

        // random mix
        for (int k = 0; k < 500; k++) begin
            int c = int'($urandom_range(0, NCH - 1));
            int p = int'($urandom_range(0, 99));
            eng_delay = int'($urandom_range(1, 4));
            if (k % 50 == 0) single_chan_mode = 1'($urandom_range(0, 1));
            if (p < 12)      op_cfg(c, $urandom & 32'h007F_FFFF);
            else if (p < 27) op_en(c, 1'($urandom_range(0, 3) != 0));
            else if (p < 65) op_tx(c, $urandom);
            else             op_rx(c);
        end

        finished = 1;
        summary();
    end
endmodule